// File: doc/BRIEF.md
# Serial Nonvolatile Memory Command Controller

This block is the slave side of a four-wire serial port (SPI mode 0) in front of a 16K x 8 nonvolatile array. The host selects the block with an active-low select, then shifts in an instruction byte, a two-byte address and data, most significant bit first. The block decodes six instructions: set and clear a write-enable flag, read and write a small status byte, stream bytes out of the array, and program up to one 32-byte sector. A hold input pauses a transfer without losing its place.

The serial pins are sampled on the system clock and their edges are detected internally. The array sits outside the block behind a synchronous byte-wide port whose read data is valid one clock after the address. A programming pass takes a fixed number of clocks. During the first 32 of those clocks the buffered sector bytes are written. A separate protection checker watches the address on the array port and the two lock bits, and answers whether that write may happen.

Top module: `spi_flash_ctrl`

## Requirements
- R1: Serial input is taken on rising SCK edges, MSB first, and the output bit changes only after falling SCK edges. `spi_miso_oe` is 0 whenever select is high.
- R2: After reset, every command is ignored until select has gone from high to low. After reset the enable flag, the lock bits and the protect-enable bit are all 0.
- R3: Instruction 0x06 sets the write-enable flag and 0x04 clears it.
- R4: Instruction 0x05 returns the status byte {PPEN, 0, 0, 0, LK1, LK0, WEN, BUSY}, from bit 7 down to bit 0. The byte repeats for as long as select stays low.
- R5: Instruction 0x01 followed by at least one whole byte stores bit 7 of the last byte into PPEN and bits 3:2 into LK1:LK0. The update happens on the select rising edge, and only when the enable flag is set and the block is idle. It then starts a timed cycle.
- R6: Instruction 0x03 with a two-byte address streams bytes from that address upward. Only the low 14 address bits are used, and the address wraps from 0x3FFF to 0x0000.
- R7: Instruction 0x02 with a two-byte address buffers the data bytes into one aligned 32-byte sector. The low 5 address bits wrap inside the sector. The cycle starts on the select rising edge only when the enable flag is set, at least one data byte arrived, and select rose on a byte boundary.
- R8: For PROG_CYCLES clocks after a start, BUSY is 1 and every other status bit reads 1. When the cycle ends, the enable flag is cleared.
- R9: Program and status-write instructions received while BUSY is 1 have no effect.
- R10: While hold is low, SCK and SI changes are ignored. When hold returns high, the transfer continues from the same bit.
- R11: Raising select in the middle of a byte discards the command and starts no cycle.
- R12: `lock_bits` presents LK1:LK0. A sector byte is written to the array only when `wr_ok` is high for its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Active-low pause |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| mem_addr | output | ADDR_W | Array address |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, valid one clock after address |
| wr_ok | input | 1 | Protection checker verdict for mem_addr |
| lock_bits | output | 2 | Lock level for the checker |

## Verification
A wrong bit or byte counter shows up as a misaligned opcode. A dropped or flipped enable flag then appears in the very next status read, within one 16-bit frame. A busy timer or a start condition that is off shows as a status of 0xFF when idle, or a missing 0xFF right after select rises. A wrong sector pointer or write mask shows only when the array is read back, after the cycle ends, as a byte at the wrong address or an unchanged byte.

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl #(
  parameter int ADDR_W      = 14,
  parameter int SECT_W      = 5,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              spi_hold_n,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              wr_ok,
  output logic [1:0]        lock_bits
);

  localparam int SLOTS = 1 << SECT_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam int CNT_W = $clog2(PROG_CYCLES);

  localparam logic [7:0] OP_EN_SET  = 8'h06;
  localparam logic [7:0] OP_EN_CLR  = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_ARR_RD  = 8'h03;
  localparam logic [7:0] OP_ARR_PG  = 8'h02;

  logic s_sck, p_sck, s_cs, p_cs, s_si, s_hold, armed;
  logic [2:0] bitc;
  logic [1:0] bytec;
  logic [6:0] sr;
  logic [7:0] op, tx;
  logic [HI_W-1:0] hi;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-SECT_W-1:0] sect;
  logic [SECT_W-1:0] ptr;
  logic [7:0] pbuf [SLOTS];
  logic [SLOTS-1:0] mask;
  logic stw_pp;
  logic [1:0] stw_lk;
  logic ppen, wen, busy;
  logic [CNT_W-1:0] tcnt;

  wire active    = armed & ~s_cs & s_hold;
  wire sck_up    = active & s_sck & ~p_sck;
  wire sck_dn    = active & ~s_sck & p_sck;
  wire cs_fall   = ~s_cs & p_cs;
  wire cs_rise   = armed & s_cs & ~p_cs;
  wire [7:0] byte_in = {sr, s_si};
  wire byte_done = sck_up & (bitc == 3'd7);
  wire [7:0] status = busy ? 8'hFF : {ppen, 3'b000, lock_bits, wen, 1'b0};
  wire wr_phase  = busy & (tcnt < CNT_W'(SLOTS));
  wire [SECT_W-1:0] slot = tcnt[SECT_W-1:0];
  wire pg_load   = ~busy & (op == OP_ARR_PG);

  assign spi_miso    = tx[7];
  assign spi_miso_oe = active;
  assign mem_addr    = wr_phase ? {sect, slot} : rd_addr;
  assign mem_wdata   = pbuf[slot];
  assign mem_we      = wr_phase & mask[slot] & wr_ok;

  always_ff @(posedge clk) begin
    if (byte_done && bytec == 2'd3 && pg_load) pbuf[ptr] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sck <= 1'b0; p_sck <= 1'b0; s_cs <= 1'b0; p_cs <= 1'b0;
      s_si <= 1'b0; s_hold <= 1'b1; armed <= 1'b0;
      bitc <= '0; bytec <= '0; sr <= '0; op <= '0; tx <= '0;
      hi <= '0; rd_addr <= '0; sect <= '0; ptr <= '0; mask <= '0;
      stw_pp <= 1'b0; stw_lk <= '0;
      ppen <= 1'b0; lock_bits <= '0; wen <= 1'b0; busy <= 1'b0; tcnt <= '0;
    end else begin
      s_sck <= spi_sck; p_sck <= s_sck;
      s_cs <= spi_cs_n; p_cs <= s_cs;
      s_si <= spi_mosi; s_hold <= spi_hold_n;
      if (cs_fall) armed <= 1'b1;

      if (s_cs) begin
        bitc <= '0;
        bytec <= '0;
      end else if (sck_up) begin
        bitc <= bitc + 3'd1;
        sr <= byte_in[6:0];
        if (bitc == 3'd7 && bytec != 2'd3) bytec <= bytec + 2'd1;
      end

      if (byte_done) begin
        if (bytec == 2'd0) begin
          op <= byte_in;
          if (byte_in == OP_EN_SET) wen <= 1'b1;
          if (byte_in == OP_EN_CLR) wen <= 1'b0;
          if (!busy && byte_in == OP_ARR_PG) mask <= '0;
        end else if (op == OP_STAT_WR) begin
          stw_pp <= byte_in[7];
          stw_lk <= byte_in[3:2];
        end else if (op == OP_ARR_RD || op == OP_ARR_PG) begin
          if (bytec == 2'd1) hi <= byte_in[HI_W-1:0];
          if (bytec == 2'd2 && op == OP_ARR_RD) rd_addr <= {hi, byte_in};
          if (bytec == 2'd2 && pg_load) {sect, ptr} <= {hi, byte_in};
          if (bytec == 2'd3 && pg_load) begin
            mask[ptr] <= 1'b1;
            ptr <= ptr + 1'b1;
          end
        end
      end

      if (sck_dn) begin
        if (bitc == 3'd0 && op == OP_ARR_RD && bytec == 2'd3) begin
          tx <= mem_rdata;
          rd_addr <= rd_addr + 1'b1;
        end else if (bitc == 3'd0 && op == OP_STAT_RD && bytec != 2'd0) begin
          tx <= status;
        end else begin
          tx <= {tx[6:0], 1'b0};
        end
      end

      if (cs_rise && bitc == 3'd0 && wen && !busy) begin
        if (op == OP_ARR_PG && bytec == 2'd3 && |mask) begin
          busy <= 1'b1;
          tcnt <= '0;
        end else if (op == OP_STAT_WR && bytec >= 2'd2) begin
          ppen <= stw_pp;
          lock_bits <= stw_lk;
          mask <= '0;
          busy <= 1'b1;
          tcnt <= '0;
        end
      end

      if (busy) begin
        if (tcnt == CNT_W'(PROG_CYCLES - 1)) begin
          busy <= 1'b0;
          wen <= 1'b0;
          mask <= '0;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  a_r1_hiz_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |=> !spi_miso_oe);

  a_r5_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));

  a_r8_enable_cleared_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wen);

  a_r10_hold_freezes_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_hold && !s_cs) |=> ($stable(bitc) && $stable(bytec)));

endmodule

// File: tb/test_spi_flash_ctrl.sv
`timescale 1ns/1ps
module test_spi_flash_ctrl;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic miso, miso_oe, mem_we, wr_ok;
  logic [13:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 8'h00;
  logic [1:0] lock_bits;
  logic [7:0] ram [int];
  logic [7:0] rbuf [4];
  int nchk = 0, nfail = 0;
  logic [7:0] d, s1, s2;

  always #2.5 clk = ~clk;

  spi_flash_ctrl #(.ADDR_W(14), .SECT_W(5), .PROG_CYCLES(600)) i_spi_flash_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_hold_n(hold_n), .spi_miso(miso), .spi_miso_oe(miso_oe),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .wr_ok(wr_ok), .lock_bits(lock_bits));

  always @(posedge clk) begin
    if (mem_we) ram[int'(mem_addr)] = mem_wdata;
    mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
  end

  always_comb begin
    case (lock_bits)
      2'd0: wr_ok = 1'b1;
      2'd1: wr_ok = mem_addr < 14'h3000;
      2'd2: wr_ok = mem_addr < 14'h2000;
      default: wr_ok = 1'b0;
    endcase
  end

  localparam logic [21:0] VEC [5] = '{
    {14'h0000, 8'h3C}, {14'h1234, 8'hA7}, {14'h2FFF, 8'h01},
    {14'h3000, 8'hFE}, {14'h0A55, 8'h80}};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic r);
    mosi = b; tick(H); r = miso; sck = 1'b1; tick(H); sck = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] t, output logic [7:0] r);
    logic b;
    for (int i = 7; i >= 0; i--) begin sbit(t[i], b); r[i] = b; end
  endtask

  task automatic cs_on;  cs_n = 1'b0; tick(H); endtask
  task automatic cs_off; tick(H); cs_n = 1'b1; tick(H + 2); endtask

  task automatic cmd1(input logic [7:0] o);
    logic [7:0] r;
    cs_on; sbyte(o, r); cs_off;
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    cs_on; sbyte(8'h05, r); sbyte(8'h00, s); cs_off;
  endtask

  task automatic prog1(input logic [13:0] a, input logic [7:0] v);
    logic [7:0] r;
    cs_on; sbyte(8'h02, r); sbyte({2'b00, a[13:8]}, r); sbyte(a[7:0], r); sbyte(v, r); cs_off;
  endtask

  task automatic rdn(input logic [13:0] a, input int n);
    logic [7:0] r;
    cs_on; sbyte(8'h03, r); sbyte({2'b00, a[13:8]}, r); sbyte(a[7:0], r);
    for (int i = 0; i < n; i++) sbyte(8'h00, rbuf[i]);
    cs_off;
  endtask

  task automatic wait_idle;
    logic [7:0] s;
    for (int i = 0; i < 40; i++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic b;
    tick(3); rst_n = 1'b1; tick(2);
    // R2 reset state: select low through reset, block not armed
    chk("R2 oe after reset", {7'd0, miso_oe}, 8'h00);
    chk("R2 lock after reset", {6'd0, lock_bits}, 8'h00);
    chk("R12 no write after reset", {7'd0, mem_we}, 8'h00);
    sbyte(8'h06, d); cs_n = 1'b1; tick(H + 2);
    chk("R1 oe deselected", {7'd0, miso_oe}, 8'h00);
    rdsr(d);
    chk("R2 command before select fall ignored", d, 8'h00);

    // R3 and R4: enable set, status repeats
    cmd1(8'h06);
    cs_on; sbyte(8'h05, d);
    chk("R1 oe selected", {7'd0, miso_oe}, 8'h01);
    sbyte(8'h00, s1); sbyte(8'h00, s2); cs_off;
    chk("R3 enable set", s1, 8'h02);
    chk("R4 status repeats", s2, 8'h02);
    cmd1(8'h04); rdsr(d);
    chk("R3 enable clear", d, 8'h00);

    // R6 R7 vector table: program one byte, read it back
    foreach (VEC[k]) begin
      cmd1(8'h06);
      prog1(VEC[k][21:8], VEC[k][7:0]);
      wait_idle;
      rdn(VEC[k][21:8], 1);
      chk("R7 program readback", rbuf[0], VEC[k][7:0]);
    end

    // R7 sector wrap of the low address bits
    cmd1(8'h06);
    cs_on; sbyte(8'h02, d); sbyte(8'h01, d); sbyte(8'h1E, d);
    sbyte(8'hAA, d); sbyte(8'hBB, d); sbyte(8'hCC, d); sbyte(8'hDD, d); cs_off;
    wait_idle;
    rdn(14'h011E, 3);
    chk("R7 slot 1E", rbuf[0], 8'hAA);
    chk("R7 slot 1F", rbuf[1], 8'hBB);
    chk("R7 next sector untouched", rbuf[2], 8'h00);
    rdn(14'h0100, 2);
    chk("R7 wrapped slot 00", rbuf[0], 8'hCC);
    chk("R7 wrapped slot 01", rbuf[1], 8'hDD);

    // R6 array read wraps at top
    cmd1(8'h06); prog1(14'h3FFF, 8'hA5); wait_idle;
    rdn(14'h3FFF, 2);
    chk("R6 top byte", rbuf[0], 8'hA5);
    chk("R6 wrap to zero", rbuf[1], 8'h3C);

    // R7 program without enable
    prog1(14'h0030, 8'h77); rdsr(d);
    chk("R7 no start without enable", d, 8'h00);
    rdn(14'h0030, 1);
    chk("R7 no write without enable", rbuf[0], 8'h00);

    // R11 partial byte at select rise
    cmd1(8'h06);
    cs_on; sbyte(8'h02, d); sbyte(8'h00, d); sbyte(8'h20, d);
    for (int i = 0; i < 4; i++) sbit(1'b1, b);
    cs_off; rdsr(d);
    chk("R11 partial byte no cycle", d, 8'h02);
    rdn(14'h0020, 1);
    chk("R11 partial byte no write", rbuf[0], 8'h00);
    cmd1(8'h04);

    // R5 status write needs enable
    cs_on; sbyte(8'h01, d); sbyte(8'h0C, d); cs_off; rdsr(d);
    chk("R5 status write without enable", d, 8'h00);

    // R5 R8 status write with enable
    cmd1(8'h06);
    cs_on; sbyte(8'h01, d); sbyte(8'h8C, d); cs_off;
    rdsr(d);
    chk("R8 busy status all ones", d, 8'hFF);
    wait_idle; rdsr(d);
    chk("R5 R8 status after write", d, 8'h8C);
    chk("R12 lock output", {6'd0, lock_bits}, 8'h03);

    // R12 locked array: cycle runs, byte not written
    cmd1(8'h06); prog1(14'h0010, 8'h99); wait_idle;
    rdn(14'h0010, 1);
    chk("R12 locked write blocked", rbuf[0], 8'h00);
    cmd1(8'h06);
    cs_on; sbyte(8'h01, d); sbyte(8'h00, d); cs_off; wait_idle; rdsr(d);
    chk("R5 unlock", d, 8'h00);

    // R9 commands during busy ignored
    cmd1(8'h06); prog1(14'h0040, 8'h11);
    cmd1(8'h06); prog1(14'h0041, 8'h22);
    wait_idle;
    rdn(14'h0040, 2);
    chk("R9 first program done", rbuf[0], 8'h11);
    chk("R9 program during busy ignored", rbuf[1], 8'h00);
    rdsr(d);
    chk("R8 enable cleared at end", d, 8'h00);

    // R10 hold pause mid opcode
    cs_on;
    sbit(1'b0, b); sbit(1'b0, b); sbit(1'b0, b); sbit(1'b0, b);
    hold_n = 1'b0; tick(H);
    for (int i = 0; i < 3; i++) begin mosi = 1'b1; tick(H); sck = 1'b1; tick(H); sck = 1'b0; end
    tick(H); hold_n = 1'b1; tick(H);
    sbit(1'b0, b); sbit(1'b1, b); sbit(1'b1, b); sbit(1'b0, b);
    cs_off; rdsr(d);
    chk("R10 hold resumes same bit", d, 8'h02);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule